// File: doc/BRIEF.md
# Multi-Core Register Read Steering Router

This block sits between the byte-level side of a serial-bus register slave and a set of identical per-core register banks. The slave reports the start of an access with its sub-address, then issues write strobes with data bytes or read strobes that expect a byte back. The router decides which core bank receives each write and which bank supplies each read byte. It also holds a small set of local registers: a core-select register, a window onto a wide indirect address space, and an interrupt mask with sticky status.

A single select register carries one read/write enable bit per core plus two walking controls. Reads go to the lowest-numbered enabled core. With core walking on, each further read byte comes from the next enabled core above the previous one, wrapping back to the lowest. With address stepping on, the sub-address advances after each byte. When both are on, the sub-address only advances when the core walk wraps. Writes to ordinary sub-addresses go to every enabled core at once. Indirect accesses load a 24-bit address through three window bytes and then move data through one data window. The indirect address steps by one on every data access.

Top module: `regsteer_top`

## Requirements
- R1: After reset the select register (sub-address 0xFF) reads 0x01. Its bits 3:0 are core enables (bit n enables core n), bit 4 turns on core walking and bit 5 turns on address stepping. Bits 7:6 read as zero.
- R2: With core walking off, a read of a core sub-address returns the byte of the lowest-numbered enabled core at the current sub-address.
- R3: With core walking on, each read after the start of an access comes from the next higher enabled core, and the walk wraps from the highest enabled core to the lowest. A new access start or a write to the select register restarts the walk at the lowest enabled core.
- R4: With address stepping on and core walking off, each read or write byte advances the sub-address by one. With stepping off, the sub-address is held.
- R5: With both walking and stepping on, the sub-address is held while the walk moves up through the enabled cores, and advances by one on the read that wraps the walk.
- R6: A write to any sub-address other than the select, window, mask and status registers reaches every enabled core in the same cycle and no disabled core.
- R7: Sub-addresses 0xE8, 0xE9 and 0xEA hold the indirect address bits 7:0, 15:8 and 23:16. They are writable and read back.
- R8: A write to sub-address 0xE0 issues one indirect write of the byte at the current indirect address. A read of 0xE0 issues one indirect read and returns its data. Each such access increments the 24-bit indirect address by one.
- R9: A core read with no core enabled returns 0x00.
- R10: Sub-address 0xF1 is the interrupt mask (reset 0x00). Sub-address 0xF2 reads the sticky event bits ANDed with the mask, and writing 1 to a bit of 0xF2 clears that sticky bit. The irq output is high while any masked status bit is set, and it falls once all of them are cleared.
- R11: Read data is registered. rd_valid is high for exactly the cycle after a read strobe, and rd_data holds that byte during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Start of an access; loads host_addr as the sub-address |
| host_addr | input | 8 | Sub-address of a new access |
| wr_stb | input | 1 | Write one data byte |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Request one read byte |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data valid (cycle after rd_stb) |
| bank_addr | output | 8 | Sub-address presented to all core banks |
| bank_wdata | output | 8 | Write data to core banks |
| bank_we | output | 4 | Per-core write enable |
| bank_rdata | input | 32 | Read data of all core banks, core n at bits 8n+7:8n |
| ind_addr | output | 24 | Indirect bus address |
| ind_wdata | output | 8 | Indirect bus write data |
| ind_wr | output | 1 | Indirect write strobe |
| ind_rd | output | 1 | Indirect read strobe |
| ind_rdata | input | 8 | Indirect bus read data (same cycle) |
| irq_evt | input | 8 | Raw interrupt event pulses |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the router with its defaults: four cores, byte-wide data and sub-addresses, a 24-bit indirect address and eight interrupt lines. Four cores are enough to build enable patterns with gaps (cores 1 and 3, cores 0 and 2), so the walk has to skip disabled cores and wrap from core 3 back to core 1. The three-byte window lets an indirect address be loaded with stepping on and then watched as it increments across data accesses. Each core bank in the bench holds a pattern that differs per core and per address, so a read from the wrong core or the wrong address shows up as a different byte.

// File: rtl/regsteer_pkg.sv
package regsteer_pkg;

  typedef enum logic [2:0] {
    RG_CORE  = 3'd0,
    RG_SEL   = 3'd1,
    RG_IADDR = 3'd2,
    RG_IDATA = 3'd3,
    RG_IMASK = 3'd4,
    RG_ISTAT = 3'd5
  } region_e;

  localparam int SEL_W    = 6;
  localparam int CINC_BIT = 4;
  localparam int AINC_BIT = 5;

endpackage

// File: rtl/rs_core_walker.sv
module rs_core_walker #(
  parameter  int NCORE = 4,
  localparam int IW    = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] en_cur,
  input  logic [NCORE-1:0] en_new,
  input  logic             restart,
  input  logic             step,
  output logic [IW-1:0]    cur,
  output logic             any_en,
  output logic             at_last
);

  logic [IW-1:0] cur_q, cur_d;
  logic [IW-1:0] low_new, low_cur, above;
  logic          found;

  function automatic logic [IW-1:0] lowest(input logic [NCORE-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  always_comb begin
    low_new = lowest(en_new);
    low_cur = lowest(en_cur);
    above   = '0;
    found   = 1'b0;
    for (int i = NCORE - 1; i >= 0; i--) begin
      if (en_cur[i] && (i > int'(cur_q))) begin
        above = IW'(i);
        found = 1'b1;
      end
    end
  end

  assign any_en  = |en_cur;
  assign at_last = !found;

  always_comb begin
    cur_d = cur_q;
    if (restart) begin
      cur_d = low_new;
    end else if (step && any_en) begin
      cur_d = found ? above : low_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;

  AST_CUR_ON_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> en_cur[cur_q]); // R3

endmodule

// File: rtl/rs_ind_window.sv
module rs_ind_window #(
  parameter  int IAW = 24,
  parameter  int DW  = 8,
  localparam int NB  = IAW / DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NB-1:0]  byte_we,
  input  logic [DW-1:0]  wdata,
  input  logic           access,
  output logic [IAW-1:0] addr
);

  logic [IAW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (access) addr_d = addr_q + IAW'(1);
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [DW-1:0] byte_d;
      always_comb begin
        byte_d = byte_we[b] ? wdata : addr_d[b*DW +: DW];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q[b*DW +: DW] <= '0;
        else        addr_q[b*DW +: DW] <= byte_d;
      end
    end
  endgenerate

  assign addr = addr_q;

  AST_IND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (access && (byte_we == '0)) |=> (addr_q == $past(addr_q) + IAW'(1))); // R8

endmodule

// File: rtl/rs_irq_unit.sv
module rs_irq_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output logic [W-1:0] status,
  output logic         irq
);

  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] sticky_q, sticky_d;

  always_comb begin
    mask_d   = mask_we ? wdata : mask_q;
    sticky_d = sticky_q;
    if (clr_we) sticky_d = sticky_d & ~wdata;
    sticky_d = sticky_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      sticky_q <= '0;
    end else begin
      mask_q   <= mask_d;
      sticky_q <= sticky_d;
    end
  end

  assign mask   = mask_q;
  assign status = sticky_q & mask_q;
  assign irq    = |status;

  AST_IRQ_LOW_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q == '0) |-> !irq); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt & mask_q)) && !mask_we) |=> irq); // R10

endmodule

// File: rtl/regsteer_top.sv
module regsteer_top #(
  parameter  int         NCORE      = 4,
  parameter  int         AW         = 8,
  parameter  int         DW         = 8,
  parameter  int         IAW        = 24,
  parameter  int         IRQW       = 8,
  parameter  logic [7:0] SEL_ADDR   = 8'hFF,
  parameter  logic [7:0] SEL_RESET  = 8'h01,
  parameter  logic [7:0] IADDR_BASE = 8'hE8,
  parameter  logic [7:0] IDATA_ADDR = 8'hE0,
  parameter  logic [7:0] MASK_ADDR  = 8'hF1,
  parameter  logic [7:0] STAT_ADDR  = 8'hF2,
  localparam int         NB         = IAW / DW,
  localparam int         IW         = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_start,
  input  logic [AW-1:0]       host_addr,
  input  logic                wr_stb,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_stb,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid,
  output logic [AW-1:0]       bank_addr,
  output logic [DW-1:0]       bank_wdata,
  output logic [NCORE-1:0]    bank_we,
  input  logic [NCORE*DW-1:0] bank_rdata,
  output logic [IAW-1:0]      ind_addr,
  output logic [DW-1:0]       ind_wdata,
  output logic                ind_wr,
  output logic                ind_rd,
  input  logic [DW-1:0]       ind_rdata,
  input  logic [IRQW-1:0]     irq_evt,
  output logic                irq
);

  import regsteer_pkg::*;

  logic [AW-1:0]    ptr_q, ptr_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_we;
  region_e          region;
  logic [NB-1:0]    iaddr_we;
  logic [IW-1:0]    cur;
  logic             any_en, at_last, walk_wrap;
  logic             cinc, ainc, step_ptr;
  logic [DW-1:0]    rdata_mux, rdata_q, rdata_d;
  logic             rvalid_q;
  logic [IRQW-1:0]  irq_mask, irq_status;
  logic [DW-1:0]    iaddr_byte;

  // sub-address decode
  always_comb begin
    region = RG_CORE;
    if (ptr_q == AW'(SEL_ADDR))                  region = RG_SEL;
    else if (ptr_q == AW'(IDATA_ADDR))           region = RG_IDATA;
    else if (ptr_q == AW'(MASK_ADDR))            region = RG_IMASK;
    else if (ptr_q == AW'(STAT_ADDR))            region = RG_ISTAT;
    else if ((ptr_q >= AW'(IADDR_BASE)) &&
             (ptr_q <  AW'(IADDR_BASE) + AW'(NB))) region = RG_IADDR;
  end

  assign cinc = sel_q[CINC_BIT];
  assign ainc = sel_q[AINC_BIT];

  // select register
  assign sel_we = wr_stb && (region == RG_SEL);
  always_comb begin
    sel_d = sel_we ? wr_data[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_RESET[SEL_W-1:0];
    else        sel_q <= sel_d;
  end

  rs_core_walker #(.NCORE(NCORE)) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_cur  (sel_q[NCORE-1:0]),
    .en_new  (sel_d[NCORE-1:0]),
    .restart (host_start || sel_we),
    .step    (rd_stb && cinc),
    .cur     (cur),
    .any_en  (any_en),
    .at_last (at_last)
  );

  assign walk_wrap = at_last || !any_en;

  // sub-address pointer
  always_comb begin
    step_ptr = (wr_stb && ainc) || (rd_stb && ainc && (!cinc || walk_wrap));
    ptr_d    = ptr_q;
    if (host_start)    ptr_d = host_addr;
    else if (step_ptr) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // core bank side: broadcast writes
  assign bank_addr  = ptr_q;
  assign bank_wdata = wr_data;
  assign bank_we    = (wr_stb && (region == RG_CORE)) ? sel_q[NCORE-1:0] : '0;

  // indirect window
  generate
    for (genvar b = 0; b < NB; b++) begin : g_iwe
      assign iaddr_we[b] = wr_stb && (ptr_q == AW'(IADDR_BASE) + AW'(b));
    end
  endgenerate

  rs_ind_window #(.IAW(IAW), .DW(DW)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (iaddr_we),
    .wdata   (wr_data),
    .access  ((wr_stb || rd_stb) && (region == RG_IDATA)),
    .addr    (ind_addr)
  );

  assign ind_wdata = wr_data;
  assign ind_wr    = wr_stb && (region == RG_IDATA);
  assign ind_rd    = rd_stb && (region == RG_IDATA);

  // interrupt mask / status
  rs_irq_unit #(.W(IRQW)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (irq_evt),
    .mask_we (wr_stb && (region == RG_IMASK)),
    .clr_we  (wr_stb && (region == RG_ISTAT)),
    .wdata   (wr_data[IRQW-1:0]),
    .mask    (irq_mask),
    .status  (irq_status),
    .irq     (irq)
  );

  // read data selection
  always_comb begin
    iaddr_byte = '0;
    for (int b = 0; b < NB; b++) begin
      if (ptr_q == AW'(IADDR_BASE) + AW'(b)) iaddr_byte = ind_addr[b*DW +: DW];
    end
  end

  always_comb begin
    unique case (region)
      RG_SEL:   rdata_mux = DW'(sel_q);
      RG_IADDR: rdata_mux = iaddr_byte;
      RG_IDATA: rdata_mux = ind_rdata;
      RG_IMASK: rdata_mux = DW'(irq_mask);
      RG_ISTAT: rdata_mux = DW'(irq_status);
      default:  rdata_mux = any_en ? bank_rdata[cur*DW +: DW] : '0;
    endcase
  end

  always_comb begin
    rdata_d = rd_stb ? rdata_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rd_stb;
    end
  end

  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid); // R11
  AST_RD_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid); // R11
  AST_BANK_WE_NOT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_we) |-> (!ind_wr && !sel_we)); // R6
  AST_PTR_HOLD_MIDWALK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && cinc && any_en && !at_last && !host_start) |=> $stable(ptr_q)); // R5

endmodule

// File: tb/regsteer_top_tb.sv
module regsteer_top_tb;

  logic        clk;
  logic        rst_n;
  logic        host_start;
  logic [7:0]  host_addr;
  logic        wr_stb;
  logic [7:0]  wr_data;
  logic        rd_stb;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  bank_addr;
  logic [7:0]  bank_wdata;
  logic [3:0]  bank_we;
  logic [31:0] bank_rdata;
  logic [23:0] ind_addr;
  logic [7:0]  ind_wdata;
  logic        ind_wr;
  logic        ind_rd;
  logic [7:0]  ind_rdata;
  logic [7:0]  irq_evt;
  logic        irq;

  int n_chk;
  int n_fail;
  logic done;

  logic [7:0]  mem [4][256];
  logic [23:0] log_waddr;
  logic [7:0]  log_wdata;
  int          n_indwr;

  regsteer_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_start (host_start),
    .host_addr  (host_addr),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .rd_stb     (rd_stb),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata),
    .bank_we    (bank_we),
    .bank_rdata (bank_rdata),
    .ind_addr   (ind_addr),
    .ind_wdata  (ind_wdata),
    .ind_wr     (ind_wr),
    .ind_rd     (ind_rd),
    .ind_rdata  (ind_rdata),
    .irq_evt    (irq_evt),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int c, input int a);
    return 8'(a) ^ 8'(c << 6) ^ 8'h11;
  endfunction

  // bank and indirect bus models
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 256; a++) mem[c][a] = pat(c, a);
      n_indwr = 0;
      log_waddr = '0;
      log_wdata = '0;
    end else begin
      for (int c = 0; c < 4; c++)
        if (bank_we[c]) mem[c][bank_addr] = bank_wdata;
      if (ind_wr) begin
        log_waddr = ind_addr;
        log_wdata = ind_wdata;
        n_indwr++;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 4; c++) bank_rdata[c*8 +: 8] = mem[c][bank_addr];
  end
  assign ind_rdata = ind_addr[7:0] ^ 8'hA5;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [7:0] a);
    @(negedge clk);
    host_start = 1'b1;
    host_addr  = a;
    @(negedge clk);
    host_start = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R11 rd_valid", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic set_sel(input logic [7:0] v);
    start(8'hFF);
    wr(v);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 rd_valid idle", 32'(rd_valid), 32'd0);
    chk("R10 irq at reset", 32'(irq), 32'd0);
    start(8'hFF);
    rd(d);
    chk("R1 select reset", 32'(d), 32'h01);
    set_sel(8'hFF);
    start(8'hFF);
    rd(d);
    chk("R1 select upper bits", 32'(d), 32'h3F);
  endtask

  task automatic t_lowest();
    logic [7:0] d;
    set_sel(8'h0E);
    start(8'h10);
    rd(d);
    chk("R2 lowest core1", 32'(d), 32'(pat(1, 8'h10)));
    set_sel(8'h0F);
    start(8'h10);
    rd(d);
    chk("R2 lowest core0", 32'(d), 32'(pat(0, 8'h10)));
    rd(d);
    chk("R4 hold without step", 32'(d), 32'(pat(0, 8'h10)));
  endtask

  task automatic t_walk();
    logic [7:0] d;
    set_sel(8'h1A);
    start(8'h20);
    rd(d);
    chk("R3 walk first", 32'(d), 32'(pat(1, 8'h20)));
    rd(d);
    chk("R3 walk skip to core3", 32'(d), 32'(pat(3, 8'h20)));
    rd(d);
    chk("R3 walk wrap", 32'(d), 32'(pat(1, 8'h20)));
    start(8'h21);
    rd(d);
    chk("R3 restart on start", 32'(d), 32'(pat(1, 8'h21)));
  endtask

  task automatic t_addr_inc();
    logic [7:0] d;
    set_sel(8'h24);
    start(8'h30);
    for (int i = 0; i < 3; i++) begin
      rd(d);
      chk("R4 address step", 32'(d), 32'(pat(2, 8'h30 + i)));
    end
  endtask

  task automatic t_both();
    logic [7:0] d;
    set_sel(8'h35);
    start(8'h40);
    rd(d); chk("R5 core0 addr40", 32'(d), 32'(pat(0, 8'h40)));
    rd(d); chk("R5 core2 addr40", 32'(d), 32'(pat(2, 8'h40)));
    rd(d); chk("R5 core0 addr41", 32'(d), 32'(pat(0, 8'h41)));
    rd(d); chk("R5 core2 addr41", 32'(d), 32'(pat(2, 8'h41)));
  endtask

  task automatic t_bcast();
    logic [7:0] d;
    set_sel(8'h25);
    start(8'h50);
    wr(8'hAA);
    wr(8'hBB);
    set_sel(8'h01);
    start(8'h50); rd(d); chk("R6 core0 first", 32'(d), 32'hAA);
    start(8'h51); rd(d); chk("R6 core0 stepped", 32'(d), 32'hBB);
    set_sel(8'h02);
    start(8'h50); rd(d); chk("R6 disabled core1", 32'(d), 32'(pat(1, 8'h50)));
    set_sel(8'h04);
    start(8'h51); rd(d); chk("R6 core2", 32'(d), 32'hBB);
  endtask

  task automatic t_window();
    logic [7:0] d;
    set_sel(8'h21);
    start(8'hE8);
    wr(8'h34); wr(8'h12); wr(8'h56);
    start(8'hE8);
    rd(d); chk("R7 window low", 32'(d), 32'h34);
    rd(d); chk("R7 window mid", 32'(d), 32'h12);
    rd(d); chk("R7 window high", 32'(d), 32'h56);
    chk("R7 address port", 32'(ind_addr), 32'h561234);
    set_sel(8'h01);
    start(8'hE0);
    wr(8'h9C);
    chk("R8 indirect write count", 32'(n_indwr), 32'd1);
    chk("R8 indirect write addr", 32'(log_waddr), 32'h561234);
    chk("R8 indirect write data", 32'(log_wdata), 32'h9C);
    rd(d);
    chk("R8 indirect read data", 32'(d), 32'(8'h35 ^ 8'hA5));
    start(8'hE8);
    rd(d);
    chk("R8 address after two", 32'(d), 32'h36);
  endtask

  task automatic t_none();
    logic [7:0] d;
    set_sel(8'h00);
    start(8'h10);
    rd(d);
    chk("R9 no core", 32'(d), 32'h00);
    set_sel(8'h10);
    start(8'h10);
    rd(d);
    chk("R9 no core walking", 32'(d), 32'h00);
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk);
    irq_evt = v;
    @(negedge clk);
    irq_evt = '0;
  endtask

  task automatic t_irq();
    logic [7:0] d;
    set_sel(8'h01);
    pulse_evt(8'h04);
    start(8'hF2); rd(d);
    chk("R10 masked status", 32'(d), 32'h00);
    chk("R10 irq masked", 32'(irq), 32'd0);
    start(8'hF1); wr(8'h0C);
    start(8'hF1); rd(d);
    chk("R10 mask readback", 32'(d), 32'h0C);
    start(8'hF2); rd(d);
    chk("R10 status after unmask", 32'(d), 32'h04);
    chk("R10 irq high", 32'(irq), 32'd1);
    pulse_evt(8'h09);
    start(8'hF2); rd(d);
    chk("R10 status two bits", 32'(d), 32'h0C);
    start(8'hF2); wr(8'h04);
    chk("R10 irq still high", 32'(irq), 32'd1);
    start(8'hF2); wr(8'h08);
    chk("R10 irq falls", 32'(irq), 32'd0);
    start(8'hF2); rd(d);
    chk("R10 status cleared", 32'(d), 32'h00);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    host_start = 1'b0;
    host_addr = '0;
    wr_stb = 1'b0;
    wr_data = '0;
    rd_stb = 1'b0;
    irq_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lowest();
    t_walk();
    t_addr_inc();
    t_both();
    t_bcast();
    t_window();
    t_none();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule